// File: doc/BRIEF.md
# Four-Thread Windowed Register File with Context Scheduler

This block is the general-purpose register store of a small multithreaded RISC engine. It holds 128 words of 32 bits in two banks of 64. One read port serves each bank, and a single write port can target either bank. Each of the four hardware threads gets a private window of sixteen registers per bank when it uses relative addressing. Absolute addressing reaches every register in a bank, which lets threads exchange values.

The block also tracks which thread is running and switches threads itself. A swap request either yields, leaving the thread runnable, or puts it to sleep until its own event line is pulsed. The sleep form covers waiting on a signal and waiting on a shared memory access. When the request is accepted, the chosen thread's registers are live on the very next cycle. If no other thread can run, the engine idles for one cycle, or for as long as it must, until a thread is runnable again.

Top module: `mtrf_regfile`

## Requirements
- R1: After synchronous reset, `cur_thread` is 0, `stall` is 0, every register of both banks reads 0, and all four threads are runnable.
- R2: A relative read (`rd_x_abs`=0) returns physical entry `cur_thread*16 + idx[3:0]` of that port's bank. Port A reads bank A and port B reads bank B. Bits 5:4 of the index are ignored.
- R3: An absolute read (`rd_x_abs`=1) returns physical entry `idx[5:0]` of that port's bank, whichever thread is running.
- R4: When `wr_en` is high, `wr_data` is stored at the next rising edge. `wr_bank`=0 selects bank A and `wr_bank`=1 selects bank B. The physical entry follows the same relative or absolute mapping as a read.
- R5: When a read and an enabled write resolve to the same physical entry of the same bank in one cycle, the read returns the value being written.
- R6: An accepted swap request moves `cur_thread`, at the next edge, to the first runnable thread in the order `cur+1, cur+2, ...` (modulo 4). `stall` stays 0, so the swap costs no cycle.
- R7: A swap with `swap_sleep`=1 makes the current thread non-runnable. The round-robin choice skips such a thread until its `event_pulse` bit is pulsed. The running thread is always runnable.
- R8: A yield (`swap_sleep`=0) when no other thread is runnable raises `stall` for exactly one cycle. The same thread then continues.
- R9: When every thread sleeps, `stall` stays high and `cur_thread` stays put until an event arrives. The round-robin search then starts at `cur+1` and resumes the first runnable thread.
- R10: Without a swap request, event pulses and time leave `cur_thread` unchanged.
- R11: A swap request while `stall` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_abs | input | 1 | Bank A read mode: 1 absolute, 0 relative |
| rd_a_idx | input | 6 | Bank A read index |
| rd_a_data | output | 32 | Bank A read data (combinational) |
| rd_b_abs | input | 1 | Bank B read mode: 1 absolute, 0 relative |
| rd_b_idx | input | 6 | Bank B read index |
| rd_b_data | output | 32 | Bank B read data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_bank | input | 1 | Write bank: 0 = A, 1 = B |
| wr_abs | input | 1 | Write mode: 1 absolute, 0 relative |
| wr_idx | input | 6 | Write index |
| wr_data | input | 32 | Write data |
| swap_req | input | 1 | Current thread gives up the engine |
| swap_sleep | input | 1 | With swap_req: thread sleeps until its event |
| event_pulse | input | 4 | Per-thread wake-up pulses |
| cur_thread | output | 2 | Running thread |
| stall | output | 1 | Engine idle this cycle |

## Verification
The hardest state to reach is the all-asleep idle. Getting there takes a run of sleep swaps that walks the round-robin through every thread, then a final sleep by the last runnable thread. The bench builds that chain from a known thread order, checks the single idle cycle of a lone yield on the way, and then holds the idle state while issuing swap requests that must be ignored. It finally wakes one chosen thread so that the restart point of the round-robin can be checked. The register sweep visits every thread's window by zero-cost yields, so the relative mapping is checked for all four threads.

// File: rtl/mtrf_pkg.sv
package mtrf_pkg;
    localparam int unsigned THREADS_DEF    = 4;
    localparam int unsigned BANK_DEPTH_DEF = 64;
    localparam int unsigned DATA_W_DEF     = 32;
    localparam int unsigned NUM_BANKS      = 2;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    typedef enum logic {
        MODE_REL = 1'b0,
        MODE_ABS = 1'b1
    } addr_mode_e;
endpackage

// File: rtl/mtrf_addr_map.sv
module mtrf_addr_map #(
    parameter int unsigned IDX_W = 6,
    parameter int unsigned TID_W = 2,
    parameter int unsigned WIN   = 16,
    parameter int unsigned WIN_W = 4
) (
    input  mtrf_pkg::addr_mode_e mode,
    input  logic [IDX_W-1:0]     idx,
    input  logic [TID_W-1:0]     tid,
    output logic [IDX_W-1:0]     phys
);
    logic [IDX_W-1:0] window_base;
    logic [IDX_W-1:0] window_off;

    always_comb begin
        window_base = IDX_W'(tid) * IDX_W'(WIN);
        window_off  = IDX_W'(idx[WIN_W-1:0]);
        if (mode == mtrf_pkg::MODE_ABS) begin
            phys = idx;
        end else begin
            phys = window_base + window_off;
        end
    end
endmodule

// File: rtl/mtrf_bank.sv
module mtrf_bank #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                store[i] <= '0;
            end
        end else if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Write-through: a same-cycle write to the read entry is forwarded.
    always_comb begin
        if (we && (waddr == raddr)) begin
            rdata = wdata;
        end else begin
            rdata = store[raddr];
        end
    end
endmodule

// File: rtl/mtrf_sched.sv
module mtrf_sched #(
    parameter int unsigned THREADS = 4,
    parameter int unsigned TID_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               swap_req,
    input  logic               swap_sleep,
    input  logic [THREADS-1:0] event_pulse,
    output logic [TID_W-1:0]   cur,
    output logic               stall,
    output logic [THREADS-1:0] ready_q
);
    logic [THREADS-1:0] cur_oh;
    logic [THREADS-1:0] runnable;
    logic [THREADS-1:0] pool;
    logic [THREADS-1:0] ready_n;
    logic               found;
    logic [TID_W-1:0]   pick;
    logic               swap_now;

    assign swap_now = swap_req && !stall;
    assign cur_oh   = THREADS'(1) << cur;
    assign runnable = ready_q | event_pulse;
    // While idle the current thread may be resumed; on a swap it is excluded.
    assign pool     = stall ? runnable : (runnable & ~cur_oh);

    always_comb begin
        found = 1'b0;
        pick  = cur;
        for (int k = 1; k <= int'(THREADS); k++) begin
            if (!found && pool[(int'(cur) + k) % int'(THREADS)]) begin
                found = 1'b1;
                pick  = TID_W'((int'(cur) + k) % int'(THREADS));
            end
        end
    end

    always_comb begin
        ready_n = runnable;
        if (swap_now && swap_sleep) begin
            ready_n = (runnable & ~cur_oh) | (event_pulse & cur_oh);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            stall   <= 1'b0;
            ready_q <= '1;
        end else begin
            ready_q <= ready_n;
            if (stall) begin
                if (found) begin
                    cur   <= pick;
                    stall <= 1'b0;
                end
            end else if (swap_req) begin
                if (found) begin
                    cur <= pick;
                end else begin
                    stall <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mtrf_regfile.sv
module mtrf_regfile #(
    parameter int unsigned THREADS    = mtrf_pkg::THREADS_DEF,
    parameter int unsigned BANK_DEPTH = mtrf_pkg::BANK_DEPTH_DEF,
    parameter int unsigned DATA_W     = mtrf_pkg::DATA_W_DEF,
    parameter int unsigned TID_W      = $clog2(THREADS),
    parameter int unsigned IDX_W      = $clog2(BANK_DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_a_abs,
    input  logic [IDX_W-1:0]   rd_a_idx,
    output logic [DATA_W-1:0]  rd_a_data,
    input  logic               rd_b_abs,
    input  logic [IDX_W-1:0]   rd_b_idx,
    output logic [DATA_W-1:0]  rd_b_data,
    input  logic               wr_en,
    input  logic               wr_bank,
    input  logic               wr_abs,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               swap_req,
    input  logic               swap_sleep,
    input  logic [THREADS-1:0] event_pulse,
    output logic [TID_W-1:0]   cur_thread,
    output logic               stall
);
    import mtrf_pkg::*;

    localparam int unsigned WIN   = BANK_DEPTH / THREADS;
    localparam int unsigned WIN_W = $clog2(WIN);

    logic [THREADS-1:0] ready_q;
    logic [IDX_W-1:0]   rd_phys_a;
    logic [IDX_W-1:0]   rd_phys_b;
    logic [IDX_W-1:0]   wr_phys;
    bank_e              wr_sel;

    logic [IDX_W-1:0]   rd_phys [NUM_BANKS];
    logic [DATA_W-1:0]  rd_data [NUM_BANKS];
    addr_mode_e         rd_mode [NUM_BANKS];
    logic [IDX_W-1:0]   rd_idx  [NUM_BANKS];

    assign wr_sel     = bank_e'(wr_bank);
    assign rd_mode[0] = addr_mode_e'(rd_a_abs);
    assign rd_mode[1] = addr_mode_e'(rd_b_abs);
    assign rd_idx[0]  = rd_a_idx;
    assign rd_idx[1]  = rd_b_idx;
    assign rd_phys_a  = rd_phys[0];
    assign rd_phys_b  = rd_phys[1];
    assign rd_a_data  = rd_data[0];
    assign rd_b_data  = rd_data[1];

    mtrf_sched #(
        .THREADS (THREADS),
        .TID_W   (TID_W)
    ) u_sched (
        .clk         (clk),
        .rst         (rst),
        .swap_req    (swap_req),
        .swap_sleep  (swap_sleep),
        .event_pulse (event_pulse),
        .cur         (cur_thread),
        .stall       (stall),
        .ready_q     (ready_q)
    );

    mtrf_addr_map #(
        .IDX_W (IDX_W), .TID_W (TID_W), .WIN (WIN), .WIN_W (WIN_W)
    ) u_wr_map (
        .mode (addr_mode_e'(wr_abs)),
        .idx  (wr_idx),
        .tid  (cur_thread),
        .phys (wr_phys)
    );

    for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_en && (wr_sel == bank_e'(1'(b)));

        mtrf_addr_map #(
            .IDX_W (IDX_W), .TID_W (TID_W), .WIN (WIN), .WIN_W (WIN_W)
        ) u_rd_map (
            .mode (rd_mode[b]),
            .idx  (rd_idx[b]),
            .tid  (cur_thread),
            .phys (rd_phys[b])
        );

        mtrf_bank #(
            .DATA_W (DATA_W), .DEPTH (BANK_DEPTH), .IDX_W (IDX_W)
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (bank_we),
            .waddr (wr_phys),
            .wdata (wr_data),
            .raddr (rd_phys[b]),
            .rdata (rd_data[b])
        );
    end
endmodule

// File: rtl/mtrf_checker.sv
module mtrf_checker #(
    parameter int unsigned THREADS = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned TID_W   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               swap_req,
    input logic [THREADS-1:0] event_pulse,
    input logic [THREADS-1:0] ready_q,
    input logic [TID_W-1:0]   cur_thread,
    input logic               stall,
    input logic               wr_en,
    input logic               wr_bank,
    input logic [IDX_W-1:0]   wr_phys,
    input logic [DATA_W-1:0]  wr_data,
    input logic [IDX_W-1:0]   rd_phys_a,
    input logic [DATA_W-1:0]  rd_a_data
);
    logic [THREADS-1:0] cur_oh;
    logic [THREADS-1:0] others;
    logic               wr_to_a;

    always_comb begin
        cur_oh  = THREADS'(1) << cur_thread;
        others  = (ready_q | event_pulse) & ~cur_oh;
        wr_to_a = wr_en && !wr_bank;
    end

    p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_to_a && (wr_phys == rd_phys_a)) |-> (rd_a_data == wr_data));

    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        wr_to_a |=> ((rd_phys_a != $past(wr_phys)) || wr_to_a
                     || (rd_a_data == $past(wr_data))));

    p_swap_moves_r6: assert property (@(posedge clk) disable iff (rst)
        (!stall && swap_req && (others != '0))
        |=> (!stall && (cur_thread != $past(cur_thread))));

    p_running_ready_r7: assert property (@(posedge clk) disable iff (rst)
        !stall |-> ready_q[cur_thread]);

    p_lone_yield_stalls_r8: assert property (@(posedge clk) disable iff (rst)
        (!stall && swap_req && (others == '0)) |=> (stall && $stable(cur_thread)));

    p_hold_no_swap_r10: assert property (@(posedge clk) disable iff (rst)
        (!stall && !swap_req) |=> (!stall && $stable(cur_thread)));

    p_idle_ignores_swap_r11: assert property (@(posedge clk) disable iff (rst)
        (stall && ((ready_q | event_pulse) == '0)) |=> (stall && $stable(cur_thread)));
endmodule

bind mtrf_regfile mtrf_checker #(
    .THREADS (THREADS),
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W),
    .TID_W   (TID_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .swap_req    (swap_req),
    .event_pulse (event_pulse),
    .ready_q     (ready_q),
    .cur_thread  (cur_thread),
    .stall       (stall),
    .wr_en       (wr_en),
    .wr_bank     (wr_bank),
    .wr_phys     (wr_phys),
    .wr_data     (wr_data),
    .rd_phys_a   (rd_phys_a),
    .rd_a_data   (rd_a_data)
);

// File: tb/tb_mtrf_regfile.sv
module tb_mtrf_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_a_abs = 1'b0, rd_b_abs = 1'b0;
    logic [5:0]  rd_a_idx = '0, rd_b_idx = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic        wr_en = 1'b0, wr_bank = 1'b0, wr_abs = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        swap_req = 1'b0, swap_sleep = 1'b0;
    logic [3:0]  event_pulse = '0;
    logic [1:0]  cur_thread;
    logic        stall;

    int total = 0;
    int failed = 0;

    always #5 clk = ~clk;

    mtrf_regfile dut (
        .clk (clk), .rst (rst),
        .rd_a_abs (rd_a_abs), .rd_a_idx (rd_a_idx), .rd_a_data (rd_a_data),
        .rd_b_abs (rd_b_abs), .rd_b_idx (rd_b_idx), .rd_b_data (rd_b_data),
        .wr_en (wr_en), .wr_bank (wr_bank), .wr_abs (wr_abs),
        .wr_idx (wr_idx), .wr_data (wr_data),
        .swap_req (swap_req), .swap_sleep (swap_sleep),
        .event_pulse (event_pulse),
        .cur_thread (cur_thread), .stall (stall)
    );

    function automatic logic [31:0] fill_val(int b, int p);
        return 32'h1000_0000 * (b + 1) + 32'h0001_0003 * p;
    endfunction

    function automatic logic [31:0] new_val(int b, int p);
        return fill_val(b, p) ^ 32'hFFFF_0000;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - failed, total);
    endtask

    task automatic swap(logic sleep);
        @(negedge clk);
        swap_req = 1'b1; swap_sleep = sleep;
        @(negedge clk);
        swap_req = 1'b0; swap_sleep = 1'b0;
        #1;
    endtask

    task automatic pulse(logic [3:0] m);
        @(negedge clk);
        event_pulse = m;
        @(negedge clk);
        event_pulse = '0;
        #1;
    endtask

    initial begin
        #1_000_000;
        failed++; total++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 cur", 32'(cur_thread), 0);
        chk("R1 stall", 32'(stall), 0);
        rd_a_abs = 1'b1; rd_b_abs = 1'b1;
        for (int p = 0; p < 64; p++) begin
            rd_a_idx = 6'(p); rd_b_idx = 6'(p);
            #1;
            chk("R1 bankA zero", rd_a_data, 0);
            chk("R1 bankB zero", rd_b_data, 0);
        end

        // R4/R5: absolute fill with same-cycle forwarding
        for (int b = 0; b < 2; b++) begin
            for (int p = 0; p < 64; p++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_abs = 1'b1; wr_bank = 1'(b);
                wr_idx = 6'(p); wr_data = fill_val(b, p);
                rd_a_idx = 6'(p); rd_b_idx = 6'(p);
                #1;
                if (b == 0) chk("R5 fwd A", rd_a_data, fill_val(0, p));
                else        chk("R5 fwd B", rd_b_data, fill_val(1, p));
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        // R3: absolute readback
        for (int p = 0; p < 64; p++) begin
            rd_a_idx = 6'(p); rd_b_idx = 6'(p);
            #1;
            chk("R3 abs A", rd_a_data, fill_val(0, p));
            chk("R3 abs B", rd_b_data, fill_val(1, p));
        end

        // R2/R4/R5/R6: per-thread window sweep
        for (int t = 0; t < 4; t++) begin
            chk("R6 thread order", 32'(cur_thread), 32'(t));
            chk("R6 no stall", 32'(stall), 0);
            rd_a_abs = 1'b0; rd_b_abs = 1'b0;
            for (int r = 0; r < 16; r++) begin
                rd_a_idx = 6'(r + 16 * ((r + t) % 4));
                rd_b_idx = 6'(r + 16 * ((r + 3 * t + 1) % 4));
                #1;
                chk("R2 rel A", rd_a_data, fill_val(0, t * 16 + r));
                chk("R2 rel B", rd_b_data, fill_val(1, t * 16 + r));
            end
            for (int r = 0; r < 16; r++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_abs = 1'b0; wr_bank = 1'(r % 2);
                wr_idx = 6'(r + 48); wr_data = new_val(r % 2, t * 16 + r);
                rd_a_abs = 1'b0; rd_b_abs = 1'b0;
                rd_a_idx = 6'(r); rd_b_idx = 6'(r);
                #1;
                if (r % 2 == 0) begin
                    chk("R5 rel fwd A", rd_a_data, new_val(0, t * 16 + r));
                    chk("R2 other bank B", rd_b_data, fill_val(1, t * 16 + r));
                end else begin
                    chk("R5 rel fwd B", rd_b_data, new_val(1, t * 16 + r));
                    chk("R2 other bank A", rd_a_data, fill_val(0, t * 16 + r));
                end
                @(negedge clk);
                wr_en = 1'b0;
                rd_a_abs = 1'b1; rd_b_abs = 1'b1;
                rd_a_idx = 6'(t * 16 + r); rd_b_idx = 6'(t * 16 + r);
                #1;
                if (r % 2 == 0) chk("R4 rel write A", rd_a_data, new_val(0, t * 16 + r));
                else            chk("R4 rel write B", rd_b_data, new_val(1, t * 16 + r));
            end
            swap(1'b0);
        end
        chk("R6 wrap to 0", 32'(cur_thread), 0);

        // R10: events without a swap request
        pulse(4'b1111);
        chk("R10 events only", 32'(cur_thread), 0);
        repeat (3) @(negedge clk);
        #1;
        chk("R10 idle time", 32'(cur_thread), 0);

        // R7: sleep chain 0 -> 1 -> 2 -> 3
        swap(1'b1);
        chk("R7 sleep 0 to 1", 32'(cur_thread), 1);
        swap(1'b1);
        chk("R7 sleep 1 to 2", 32'(cur_thread), 2);
        swap(1'b1);
        chk("R7 sleep 2 to 3", 32'(cur_thread), 3);
        chk("R6 sleep swap no stall", 32'(stall), 0);

        // R8: lone yield costs one cycle
        swap(1'b0);
        chk("R8 stall raised", 32'(stall), 1);
        chk("R8 same thread", 32'(cur_thread), 3);
        @(negedge clk);
        #1;
        chk("R8 stall one cycle", 32'(stall), 0);
        chk("R8 thread resumes", 32'(cur_thread), 3);

        // R9/R11: everyone asleep
        swap(1'b1);
        chk("R9 all asleep", 32'(stall), 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            swap_req = 1'b1; swap_sleep = 1'(k % 2);
            #1;
            chk("R11 stall held", 32'(stall), 1);
            chk("R11 thread held", 32'(cur_thread), 3);
        end
        @(negedge clk);
        swap_req = 1'b0; swap_sleep = 1'b0;
        pulse(4'b0010);
        chk("R9 wake thread 1", 32'(cur_thread), 1);
        chk("R9 stall cleared", 32'(stall), 0);

        // R10/R7: wake 0 while 1 runs, then round-robin skips sleepers
        pulse(4'b0001);
        chk("R10 event no switch", 32'(cur_thread), 1);
        swap(1'b0);
        chk("R7 skip 2 and 3", 32'(cur_thread), 0);
        swap(1'b0);
        chk("R7 back to 1", 32'(cur_thread), 1);
        swap(1'b0);
        chk("R7 skip again", 32'(cur_thread), 0);
        chk("R6 stall stays low", 32'(stall), 0);

        summary();
        $finish;
    end
endmodule